// File: doc/BRIEF.md
# Bus Fault Address Capture Unit

This unit watches three bus ports (instruction fetch, data and system) for fault pulses raised by their address decoders. While capture is switched on, a fault pulse on a bus stores the address that bus carried into its own register and raises a per-bus seen flag. Once a flag is up, the stored address is frozen, so software always reads the address of the first fault since the flag was last cleared.

Software uses a small single-cycle register port. It turns capture on or off, reads the three stored addresses and a status word holding the three flags, and clears the flags. A write of any value to the status word lowers all three flags at once. The stored addresses are not cleared and stay readable.

Top module: `bus_fault_capture`

## Requirements
- R1: After synchronous reset, every stored address reads 0x0, the status word reads 0x0 and the enable register reads 0x0, so capture is off.
- R2: While the enable bit is 0, a fault pulse on any bus neither sets a flag nor changes a stored address.
- R3: While the enable bit is 1 and a bus's flag is 0, a fault pulse on that bus at a clock edge sets the flag and loads that bus's address at the same edge. Both are visible on a read in the following cycle.
- R4: While a bus's flag is 1, later fault pulses on that bus leave its stored address unchanged.
- R5: A write of any data value to the status word (offset 0x0C) clears all three flags at the next edge and leaves the stored addresses unchanged.
- R6: If a status-word write and a fault pulse fall in the same cycle, the clear wins. The fault is dropped: no flag is set and no address is loaded.
- R7: Fault pulses on several buses in the same cycle are each captured in their own channel.
- R8: Register map: stored addresses for instruction fetch, data and system buses at offsets 0x00, 0x04 and 0x08. The status word is at 0x0C, with bit 0 for instruction fetch, bit 1 for data, bit 2 for system and 1 meaning a fault was seen. Enable is at 0x10. Every other offset reads 0x0.
- R9: Writes to offsets 0x00, 0x04 and 0x08 are ignored. The stored addresses keep their values.
- R10: The enable register takes bit 0 of the written data and ignores the rest. It reads back with only bit 0 possibly set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 3 | Fault pulses: bit 0 instruction fetch, bit 1 data, bit 2 system |
| flt_addr_ifetch | input | ADDR_W | Current instruction fetch bus address |
| flt_addr_data | input | ADDR_W | Current data bus address |
| flt_addr_sys | input | ADDR_W | Current system bus address |
| reg_addr | input | REG_AW | Register byte offset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The bench uses the default parameters: ADDR_W of 32 and REG_AW of 5. With full-width addresses, values with the top bit set pass through to the read data unmasked. The 5-bit offset space reaches the unused offsets 0x14 to 0x1F and unaligned offsets, so they can be read and checked for zero. Random fault patterns on all three buses run alongside random writes to every offset. The clear-versus-fault collision and the frozen-address case come up often.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    localparam int NUM_CH = 3;
    localparam int REG_W  = 32;

    typedef enum logic [1:0] {
        CH_IFETCH = 2'd0,
        CH_DATA   = 2'd1,
        CH_SYS    = 2'd2
    } chan_e;

    localparam logic [7:0] OFF_STATUS = 8'h0C;
    localparam logic [7:0] OFF_ENABLE = 8'h10;

    // Byte offset of the stored address of channel idx.
    function automatic logic [7:0] chan_off(input int idx);
        return 8'(idx * 4);
    endfunction

    typedef struct packed {
        logic status_clr;
        logic en_wr;
        logic en_val;
    } wr_cmd_t;

endpackage

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
    import bfc_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output wr_cmd_t           cmd,
    output logic              en_q
);

    always_comb begin
        cmd            = '0;
        cmd.status_clr = reg_we && (8'(reg_addr) == OFF_STATUS);
        cmd.en_wr      = reg_we && (8'(reg_addr) == OFF_ENABLE);
        cmd.en_val     = reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (cmd.en_wr) begin
            en_q <= cmd.en_val;
        end
    end

    assert_en_wr_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_we && 8'(reg_addr) == OFF_ENABLE) |=> (en_q == $past(reg_wdata[0])));

    assert_en_keep_R10: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && 8'(reg_addr) == OFF_ENABLE) |=> $stable(en_q));

endmodule

// File: rtl/bfc_channel.sv
module bfc_channel #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic              fault,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              flag_q,
    output logic [ADDR_W-1:0] addr_q
);

    logic take;
    assign take = en && fault && !flag_q && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            addr_q <= '0;
        end else if (clr) begin
            flag_q <= 1'b0;
        end else if (take) begin
            flag_q <= 1'b1;
            addr_q <= bus_addr;
        end
    end

    assert_rst_R1: assert property (@(posedge clk)
        rst |=> (!flag_q && addr_q == '0));

    assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (!en && !flag_q) |=> (!flag_q && $stable(addr_q)));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (en && fault && !flag_q && !clr) |=> (flag_q && addr_q == $past(bus_addr)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> $stable(addr_q));

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!flag_q && $stable(addr_q)));

endmodule

// File: rtl/bfc_read_mux.sv
module bfc_read_mux
    import bfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 5
) (
    input  logic              [REG_AW-1:0] reg_addr,
    input  logic              [NUM_CH-1:0] flags,
    input  logic              [ADDR_W-1:0] addrs [NUM_CH],
    input  logic                           en_q,
    output logic              [REG_W-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (8'(reg_addr) == chan_off(i)) begin
                rdata[ADDR_W-1:0] = addrs[i];
            end
        end
        if (8'(reg_addr) == OFF_STATUS) begin
            rdata[NUM_CH-1:0] = flags;
        end
        if (8'(reg_addr) == OFF_ENABLE) begin
            rdata[0] = en_q;
        end
    end

endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
    import bfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        flt_valid,
    input  logic [ADDR_W-1:0] flt_addr_ifetch,
    input  logic [ADDR_W-1:0] flt_addr_data,
    input  logic [ADDR_W-1:0] flt_addr_sys,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    wr_cmd_t           cmd;
    logic              en_q;
    logic [ADDR_W-1:0] bus_addr [NUM_CH];
    logic [ADDR_W-1:0] cap_addr [NUM_CH];
    logic [NUM_CH-1:0] flags;

    assign bus_addr[CH_IFETCH] = flt_addr_ifetch;
    assign bus_addr[CH_DATA]   = flt_addr_data;
    assign bus_addr[CH_SYS]    = flt_addr_sys;

    bfc_ctrl #(.REG_AW(REG_AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .cmd       (cmd),
        .en_q      (en_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        bfc_channel #(.ADDR_W(ADDR_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (en_q),
            .clr      (cmd.status_clr),
            .fault    (flt_valid[g]),
            .bus_addr (bus_addr[g]),
            .flag_q   (flags[g]),
            .addr_q   (cap_addr[g])
        );
    end

    bfc_read_mux #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_rmux (
        .reg_addr (reg_addr),
        .flags    (flags),
        .addrs    (cap_addr),
        .en_q     (en_q),
        .rdata    (reg_rdata)
    );

    assert_ro_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_we && 8'(reg_addr) < OFF_STATUS && flt_valid == '0)
        |=> ($stable(cap_addr[0]) && $stable(cap_addr[1]) && $stable(cap_addr[2])));

    assert_clear_all_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_we && 8'(reg_addr) == OFF_STATUS) |=> (flags == '0));

endmodule

// File: tb/bus_fault_capture_tb.sv
`timescale 1ns/1ps
module bus_fault_capture_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  flt_valid = '0;
    logic [31:0] fa0 = '0, fa1 = '0, fa2 = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int nchk = 0;
    int nerr = 0;
    logic done = 1'b0;

    logic [31:0] m_addr [3];
    logic [2:0]  m_flag;
    logic        m_en;

    always #4 clk = ~clk;

    bus_fault_capture #(.ADDR_W(32), .REG_AW(5)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .flt_valid       (flt_valid),
        .flt_addr_ifetch (fa0),
        .flt_addr_data   (fa1),
        .flt_addr_sys    (fa2),
        .reg_addr        (reg_addr),
        .reg_we          (reg_we),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata)
    );

    function automatic logic [31:0] exp_read(input logic [4:0] off);
        case (off)
            5'h00:   return m_addr[0];
            5'h04:   return m_addr[1];
            5'h08:   return m_addr[2];
            5'h0C:   return {29'd0, m_flag};
            5'h10:   return {31'd0, m_en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input logic [2:0] v, input logic [31:0] a0, input logic [31:0] a1,
                        input logic [31:0] a2, input logic we, input logic [4:0] wa,
                        input logic [31:0] wd);
        logic [31:0] aa [3];
        @(negedge clk);
        flt_valid = v; fa0 = a0; fa1 = a1; fa2 = a2;
        reg_we = we; reg_addr = wa; reg_wdata = wd;
        aa[0] = a0; aa[1] = a1; aa[2] = a2;
        if (we && wa == 5'h0C) begin
            m_flag = '0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (m_en && v[i] && !m_flag[i]) begin
                    m_flag[i] = 1'b1;
                    m_addr[i] = aa[i];
                end
            end
        end
        if (we && wa == 5'h10) m_en = wd[0];
        @(posedge clk);
        #1;
        flt_valid = '0;
        reg_we = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [4:0] off);
        logic [31:0] e;
        reg_addr = off;
        #0.2;
        e = exp_read(off);
        nchk++;
        if (reg_rdata !== e) begin
            nerr++;
            $display("FAIL %s offset 0x%02h actual 0x%08h expected 0x%08h", tag, off, reg_rdata, e);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, 5'h00);
        chk(tag, 5'h04);
        chk(tag, 5'h08);
        chk(tag, 5'h0C);
        chk(tag, 5'h10);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [4:0] offs [6];
        void'($urandom(32'd20240611));
        m_addr[0] = '0; m_addr[1] = '0; m_addr[2] = '0;
        m_flag = '0; m_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk_all("R1 reset state");

        // R2: faults ignored while capture is off
        step(3'b111, 32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 1'b0, 5'h0, 32'h0);
        chk_all("R2 disabled capture");

        // R10: only bit 0 of the enable write matters
        step(3'b000, 0, 0, 0, 1'b1, 5'h10, 32'hFFFF_FFFF);
        chk("R10 enable set", 5'h10);
        step(3'b000, 0, 0, 0, 1'b1, 5'h10, 32'hFFFF_FFFE);
        chk("R10 enable cleared by bit0", 5'h10);
        step(3'b000, 0, 0, 0, 1'b1, 5'h10, 32'h0000_0001);

        // R3: capture on instruction fetch bus
        step(3'b001, 32'h8000_1234, 32'h0, 32'h0, 1'b0, 5'h0, 32'h0);
        chk_all("R3 capture ifetch");

        // R4: frozen while flagged
        step(3'b001, 32'hDEAD_BEEF, 32'h0, 32'h0, 1'b0, 5'h0, 32'h0);
        chk_all("R4 hold ifetch");

        // R7: simultaneous faults on data and system buses
        step(3'b110, 32'h0, 32'hCAFE_0004, 32'hF00D_0008, 1'b0, 5'h0, 32'h0);
        chk_all("R7 simultaneous capture");

        // R9: address registers ignore writes
        step(3'b000, 0, 0, 0, 1'b1, 5'h00, 32'h1234_5678);
        step(3'b000, 0, 0, 0, 1'b1, 5'h04, 32'h1234_5678);
        step(3'b000, 0, 0, 0, 1'b1, 5'h08, 32'h1234_5678);
        chk_all("R9 read-only addresses");

        // R5: any data value clears every flag
        step(3'b000, 0, 0, 0, 1'b1, 5'h0C, 32'h0000_0000);
        chk_all("R5 status write clears");

        // R6: clear collides with faults on all buses
        step(3'b111, 32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003, 1'b1, 5'h0C, 32'h5A5A_5A5A);
        chk_all("R6 clear beats fault");

        // R3: fresh capture after clear
        step(3'b101, 32'h0BAD_F00D, 32'h0, 32'h7777_7777, 1'b0, 5'h0, 32'h0);
        chk_all("R3 capture after clear");

        // R8: unused and unaligned offsets read zero
        chk("R8 unused 0x14", 5'h14);
        chk("R8 unused 0x18", 5'h18);
        chk("R8 unused 0x1C", 5'h1C);
        chk("R8 unaligned 0x01", 5'h01);
        chk("R8 unaligned 0x0D", 5'h0D);

        // R2: disable again with a flag cleared, fault ignored
        step(3'b000, 0, 0, 0, 1'b1, 5'h0C, 32'h1);
        step(3'b000, 0, 0, 0, 1'b1, 5'h10, 32'h0);
        step(3'b111, 32'h9999_9999, 32'h8888_8888, 32'h6666_6666, 1'b0, 5'h0, 32'h0);
        chk_all("R2 disabled after clear");

        // Random phase
        offs[0] = 5'h00; offs[1] = 5'h04; offs[2] = 5'h08;
        offs[3] = 5'h0C; offs[4] = 5'h10; offs[5] = 5'h14;
        for (int n = 0; n < 600; n++) begin
            logic        we;
            logic [31:0] wd;
            we = ($urandom % 5) == 0;
            wd = $urandom;
            if (($urandom % 4) != 0) wd[0] = 1'b1;
            step(3'($urandom), $urandom, $urandom, $urandom, we, offs[$urandom % 6], wd);
            chk_all("R3 R4 R5 R6 R7 R9 R10 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule